// File: doc/BRIEF.md
# Burst SPI Master with Register Access

This block is a serial peripheral interface master that software drives through a small word-wide register bus. Software chooses the word length and clock mode, selects and drives the device-select lines, and loads up to four words into a transmit queue. It then writes a word count together with a start bit. The block moves the words out serially, most significant bit first, and captures the incoming line into a receive queue. When the burst ends it flags ready and, if enabled, raises an interrupt.

The serial clock is the system clock divided by a fixed parameter. Transmit and receive are gated separately, so a burst can be write-only, read-only or full duplex. Longer transfers are split by software into bursts of at most one queue depth. Each burst is started again after the ready flag is cleared.

Registers use word indexes on `regAddr`: 0 is the command register, 1 is status, 2 is transfer control, 3 is the transmit data port (write) and 4 is the receive data port (read). Read data appears on `regRData` in the cycle after `regRd`.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, status reads 0x50 (both queues empty), the command and transfer-control registers read 0, `sclk` is low, all `csN` lines are high and `irq` is low.
- R2: The word length is command bits [4:0] plus one (1 to 32 bits). Each word goes out on `mosi` most significant bit first within that length.
- R3: The word count field is transfer-control bits [15:0] and holds words minus one. A burst moves min(count+1, 4) words.
- R4: Command bit 6 sets the idle level of `sclk`. With command bit 5 clear, data is sampled on the leading edge; with bit 5 set, it is sampled on the trailing edge. `mosi` is stable at each sampling edge.
- R5: Received words are right-aligned and zero-extended. They are pushed into the receive queue only when command bit 8 is set; otherwise the receive queue stays empty.
- R6: With command bit 7 clear, the transmit queue is not popped and `mosi` stays low, but the programmed number of words is still clocked.
- R7: Command bits [12:9] enable device lines, bit 13 is the software select level and bit 14 inverts all lines. Each line is (enabled ? level : 1) XOR invert, and the lines do not change during a burst.
- R8: Writing transfer-control bit 31 as 1 starts a burst. Status bit 0 (busy) is set from that write until the burst ends. At the end, status bit 1 (ready) sets and bit 31 self-clears. Writes to the command or transfer-control register while busy are ignored.
- R9: Status layout: busy 0, ready 1, receive underflow 2, transmit overflow 3, receive empty 4, receive full 5, transmit empty 6, transmit full 7. Bits 1 to 3 clear when 1 is written to them.
- R10: A write to a full transmit queue (4 words) is dropped and sets status bit 3. A read of an empty receive queue returns 0 and sets status bit 2.
- R11: `irq` is ready AND ((transfer-control bit 16 AND transmit enabled) OR (bit 17 AND receive enabled)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| regAddr | input | 3 | Register word index |
| regWData | input | 32 | Register write data |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regRData | output | 32 | Read data, valid the cycle after regRd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Device select lines |
| irq | output | 1 | Burst completion interrupt |

## Verification
The bench runs all four clock modes with word lengths of 1, 5, 8, 12 and 32 bits. A wrong sampling edge would show up as bits shifted by one place, and a wrong bit order as a reversed word. It asks for ten words in one burst; a design that did not clamp to the queue depth would clock extra words that no queue entry supplied. It runs read-only and write-only bursts: a block that popped the transmit queue with transmit disabled would lose the preloaded word, and one that ignored the receive gate would leave data in the receive queue. It overfills the transmit queue and reads the empty receive queue, and checks the sticky flags, their write-one clearing and the interrupt gating, including a command write made while busy that must not take effect.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  // register word indexes
  localparam logic [2:0] REG_CMD  = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_XFER = 3'd2;
  localparam logic [2:0] REG_TXD  = 3'd3;
  localparam logic [2:0] REG_RXD  = 3'd4;

  // status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_RDY   = 1;
  localparam int ST_RXUNF = 2;
  localparam int ST_TXOVF = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic sampleBit;
    logic shiftBit;
    logic storeWord;
    logic finish;
  } spiStrobe_t;

endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wData,
  output logic [WIDTH-1:0] rData,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    level;

  logic doPush, doPop;
  assign full   = (level == CW'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int LEN_W    = 5,
  parameter int BURST_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [BURST_W-1:0] lastWordIdx,
  input  logic [LEN_W-1:0]   wordLen,
  output spiStrobe_t         strobe,
  output logic               shifting,
  output logic               halfIdx
);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_DONE} ctrlState_t;

  ctrlState_t         state;
  logic [DIV_W-1:0]   divCnt;
  logic [LEN_W-1:0]   bitCnt;
  logic [BURST_W-1:0] wordsLeft;
  logic               halfEnd;

  assign halfEnd  = (divCnt == DIV_W'(DIV_HALF - 1));
  assign shifting = (state == S_SHIFT);

  always_comb begin
    strobe           = '0;
    strobe.loadWord  = (state == S_LOAD);
    strobe.sampleBit = shifting && halfEnd && !halfIdx;
    strobe.shiftBit  = shifting && halfEnd && halfIdx && (bitCnt != '0);
    strobe.storeWord = shifting && halfEnd && halfIdx && (bitCnt == '0);
    strobe.finish    = (state == S_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      wordsLeft <= '0;
      halfIdx   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startReq) begin
          wordsLeft <= lastWordIdx;
          state     <= S_LOAD;
        end
        S_LOAD: begin
          bitCnt  <= wordLen;
          divCnt  <= '0;
          halfIdx <= 1'b0;
          state   <= S_SHIFT;
        end
        S_SHIFT: begin
          if (!halfEnd) begin
            divCnt <= divCnt + 1'b1;
          end else begin
            divCnt <= '0;
            if (!halfIdx) begin
              halfIdx <= 1'b1;
            end else if (bitCnt == '0) begin
              if (wordsLeft == '0) begin
                state <= S_DONE;
              end else begin
                wordsLeft <= wordsLeft - 1'b1;
                state     <= S_LOAD;
              end
            end else begin
              bitCnt  <= bitCnt - 1'b1;
              halfIdx <= 1'b0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_dp.sv
module spi_burst_dp
  import spi_burst_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CS_N       = 4,
  parameter int CNT_W      = 16,
  parameter int LEN_W      = 5,
  parameter int BURST_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWData,
  input  logic               regWr,
  input  logic               regRd,
  output logic [DATA_W-1:0]  regRData,
  input  spiStrobe_t         strobe,
  input  logic               shifting,
  input  logic               halfIdx,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [CS_N-1:0]    csN,
  output logic               irq,
  output logic               startReq,
  output logic [BURST_W-1:0] lastWordIdx,
  output logic [LEN_W-1:0]   wordLen,
  output logic               busy,
  output logic               ready,
  output logic               cpol,
  output logic               txEn,
  output logic               goBit
);
  // command field positions
  localparam int B_CPHA  = LEN_W;
  localparam int B_CPOL  = LEN_W + 1;
  localparam int B_TXEN  = LEN_W + 2;
  localparam int B_RXEN  = LEN_W + 3;
  localparam int B_CSEN  = LEN_W + 4;
  localparam int B_CSVAL = B_CSEN + CS_N;
  localparam int B_CSINV = B_CSVAL + 1;
  // transfer-control field positions
  localparam int B_TXIE  = CNT_W;
  localparam int B_RXIE  = CNT_W + 1;
  localparam int B_GO    = DATA_W - 1;

  logic            cpha, rxEn, csVal, csInv;
  logic [CS_N-1:0] csEn;
  logic [CNT_W-1:0] blkCnt;
  logic            txIe, rxIe;
  logic            rxUnf, txOvf;
  logic [DATA_W-1:0] txShift, rxShift;

  logic cmdWr, xferWr, statWr, txdWr, rxdRd;
  assign cmdWr  = regWr && (regAddr == REG_CMD)  && !busy;
  assign xferWr = regWr && (regAddr == REG_XFER) && !busy;
  assign statWr = regWr && (regAddr == REG_STAT);
  assign txdWr  = regWr && (regAddr == REG_TXD);
  assign rxdRd  = regRd && (regAddr == REG_RXD);

  // queues
  logic [DATA_W-1:0] txHead, rxHead;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txPop, rxPush;
  assign txPop  = strobe.loadWord && txEn && !txEmpty;
  assign rxPush = strobe.storeWord && rxEn;

  spi_burst_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(txdWr), .pop(txPop), .wData(regWData),
    .rData(txHead), .full(txFull), .empty(txEmpty));

  spi_burst_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(rxPush), .pop(rxdRd), .wData(rxShift),
    .rData(rxHead), .full(rxFull), .empty(rxEmpty));

  // burst length clamped to the queue depth
  assign lastWordIdx = (blkCnt >= CNT_W'(FIFO_DEPTH - 1)) ? BURST_W'(FIFO_DEPTH - 1)
                                                          : blkCnt[BURST_W-1:0];

  // configuration and status registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordLen  <= '0;
      cpha     <= 1'b0;
      cpol     <= 1'b0;
      txEn     <= 1'b0;
      rxEn     <= 1'b0;
      csEn     <= '0;
      csVal    <= 1'b0;
      csInv    <= 1'b0;
      blkCnt   <= '0;
      txIe     <= 1'b0;
      rxIe     <= 1'b0;
      goBit    <= 1'b0;
      busy     <= 1'b0;
      ready    <= 1'b0;
      rxUnf    <= 1'b0;
      txOvf    <= 1'b0;
      startReq <= 1'b0;
    end else begin
      startReq <= 1'b0;
      if (cmdWr) begin
        wordLen <= regWData[LEN_W-1:0];
        cpha    <= regWData[B_CPHA];
        cpol    <= regWData[B_CPOL];
        txEn    <= regWData[B_TXEN];
        rxEn    <= regWData[B_RXEN];
        csEn    <= regWData[B_CSEN +: CS_N];
        csVal   <= regWData[B_CSVAL];
        csInv   <= regWData[B_CSINV];
      end
      if (xferWr) begin
        blkCnt <= regWData[CNT_W-1:0];
        txIe   <= regWData[B_TXIE];
        rxIe   <= regWData[B_RXIE];
        if (regWData[B_GO]) begin
          goBit    <= 1'b1;
          busy     <= 1'b1;
          startReq <= 1'b1;
        end
      end
      if (statWr) begin
        if (regWData[ST_RDY])   ready <= 1'b0;
        if (regWData[ST_RXUNF]) rxUnf <= 1'b0;
        if (regWData[ST_TXOVF]) txOvf <= 1'b0;
      end
      if (txdWr && txFull)  txOvf <= 1'b1;
      if (rxdRd && rxEmpty) rxUnf <= 1'b1;
      if (strobe.finish) begin
        busy  <= 1'b0;
        goBit <= 1'b0;
        ready <= 1'b1;
      end
    end
  end

  // shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.loadWord) begin
        txShift <= txPop ? txHead : '0;
        rxShift <= '0;
      end else begin
        if (strobe.shiftBit)  txShift <= txShift << 1;
        if (strobe.sampleBit) rxShift <= {rxShift[DATA_W-2:0], miso};
      end
    end
  end

  assign mosi = txShift[wordLen];
  assign sclk = shifting ? ((halfIdx ^ cpha) ? ~cpol : cpol) : cpol;
  assign irq  = ready && ((txIe && txEn) || (rxIe && rxEn));

  for (genvar g = 0; g < CS_N; g++) begin : g_cs
    assign csN[g] = (csEn[g] ? csVal : 1'b1) ^ csInv;
  end

  // register read views
  logic [DATA_W-1:0] cmdView, statView, xferView;
  always_comb begin
    cmdView                  = '0;
    cmdView[LEN_W-1:0]       = wordLen;
    cmdView[B_CPHA]          = cpha;
    cmdView[B_CPOL]          = cpol;
    cmdView[B_TXEN]          = txEn;
    cmdView[B_RXEN]          = rxEn;
    cmdView[B_CSEN +: CS_N]  = csEn;
    cmdView[B_CSVAL]         = csVal;
    cmdView[B_CSINV]         = csInv;
    statView = {{(DATA_W-8){1'b0}}, txFull, txEmpty, rxFull, rxEmpty,
                txOvf, rxUnf, ready, busy};
    xferView                 = '0;
    xferView[CNT_W-1:0]      = blkCnt;
    xferView[B_TXIE]         = txIe;
    xferView[B_RXIE]         = rxIe;
    xferView[B_GO]           = goBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRData <= '0;
    end else if (regRd) begin
      case (regAddr)
        REG_CMD:  regRData <= cmdView;
        REG_STAT: regRData <= statView;
        REG_XFER: regRData <= xferView;
        REG_RXD:  regRData <= rxEmpty ? '0 : rxHead;
        default:  regRData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CS_N       = 4,
  parameter int CNT_W      = 16,
  parameter int DIV_HALF   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWData,
  input  logic              regWr,
  input  logic              regRd,
  output logic [DATA_W-1:0] regRData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_N-1:0]   csN,
  output logic              irq
);
  localparam int LEN_W   = $clog2(DATA_W);
  localparam int BURST_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  spiStrobe_t         strobeW;
  logic               shiftingW, halfIdxW, startReqW;
  logic [BURST_W-1:0] lastWordIdxW;
  logic [LEN_W-1:0]   wordLenW;
  logic               busyW, readyW, cpolW, txEnW, goW;

  spi_burst_ctrl #(.DIV_HALF(DIV_HALF), .LEN_W(LEN_W), .BURST_W(BURST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReqW), .lastWordIdx(lastWordIdxW),
    .wordLen(wordLenW), .strobe(strobeW), .shifting(shiftingW), .halfIdx(halfIdxW));

  spi_burst_dp #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CS_N(CS_N), .CNT_W(CNT_W),
                 .LEN_W(LEN_W), .BURST_W(BURST_W)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWData(regWData), .regWr(regWr),
    .regRd(regRd), .regRData(regRData), .strobe(strobeW), .shifting(shiftingW),
    .halfIdx(halfIdxW), .miso(miso), .sclk(sclk), .mosi(mosi), .csN(csN), .irq(irq),
    .startReq(startReqW), .lastWordIdx(lastWordIdxW), .wordLen(wordLenW),
    .busy(busyW), .ready(readyW), .cpol(cpolW), .txEn(txEnW), .goBit(goW));
endmodule

// File: rtl/spi_burst_checks.sv
module spi_burst_checks #(
  parameter int CS_N = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            ready,
  input logic            goBit,
  input logic            cpol,
  input logic            txEn,
  input logic            shifting,
  input logic            sclk,
  input logic            mosi,
  input logic            irq,
  input logic [CS_N-1:0] csN
);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk == cpol));

  assert_cs_steady_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csN));

  assert_end_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (ready && !goBit));

  assert_shift_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    shifting |-> busy);

  assert_quiet_mosi_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shifting && !txEn) |-> !mosi);

  assert_irq_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ready);
endmodule

bind spi_burst_master spi_burst_checks #(.CS_N(CS_N)) u_checks (
  .clk(clk), .rstN(rstN), .busy(busyW), .ready(readyW), .goBit(goW), .cpol(cpolW),
  .txEn(txEnW), .shifting(shiftingW), .sclk(sclk), .mosi(mosi), .irq(irq), .csN(csN));

// File: tb/test_spi_burst_master.sv
module test_spi_burst_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWData = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic        miso = 1'b0;
  logic [31:0] regRData;
  logic        sclk, mosi, irq;
  logic [3:0]  csN;

  int total = 0;
  int bad = 0;

  spi_burst_master i_spi_burst_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWData(regWData), .regWr(regWr),
    .regRd(regRd), .regRData(regRData), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csN(csN), .irq(irq));

  always #2.5 clk = ~clk;

  localparam logic [2:0] A_CMD = 3'd0, A_STAT = 3'd1, A_XFER = 3'd2, A_TXD = 3'd3, A_RXD = 3'd4;

  // scoreboard state
  logic [31:0] mosiQ[$];
  logic [31:0] slaveQ[$];
  logic [31:0] rxQ[$];
  int curLen = 8;
  bit curCpol = 1'b0, curCpha = 1'b0, armed = 1'b0;
  logic [31:0] mWord = '0, sWord = '0;
  int mCnt = 0, sPos = 0, monWords = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRData;
  endtask

  function automatic logic [31:0] lenMask(input int len);
    logic [63:0] m;
    m = (64'd1 << len) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] cmdWord(input int len, input bit cpha, input bit cpol,
      input bit tx, input bit rx, input logic [3:0] csE, input bit csV, input bit csI);
    logic [31:0] v;
    v = 32'(len - 1) & 32'h1F;
    v[5] = cpha; v[6] = cpol; v[7] = tx; v[8] = rx;
    v[12:9] = csE; v[13] = csV; v[14] = csI;
    return v;
  endfunction

  task automatic setCmd(input int len, input bit cpha, input bit cpol, input bit tx,
      input bit rx, input logic [3:0] csE, input bit csV, input bit csI);
    regWrite(A_CMD, cmdWord(len, cpha, cpol, tx, rx, csE, csV, csI));
    curLen = len; curCpha = cpha; curCpol = cpol;
  endtask

  // driver side of the scoreboard: what mosi must show and what the slave returns
  task automatic addWord(input logic [31:0] tx, input logic [31:0] sl, input bit txOn, input bit rxOn);
    mosiQ.push_back(txOn ? (tx & lenMask(curLen)) : 32'h0);
    slaveQ.push_back(sl & lenMask(curLen));
    if (rxOn) rxQ.push_back(sl & lenMask(curLen));
  endtask

  task automatic startBurst(input int count, input bit txIe, input bit rxIe);
    logic [31:0] v;
    mCnt = 0; mWord = '0; monWords = 0;
    sWord = (slaveQ.size() > 0) ? slaveQ.pop_front() : 32'h0;
    sPos = curLen - 1;
    miso = sWord[sPos];
    armed = 1'b1;
    v = 32'(count) & 32'hFFFF;
    v[16] = txIe; v[17] = rxIe; v[31] = 1'b1;
    regWrite(A_XFER, v);
  endtask

  task automatic waitBurst();
    logic [31:0] st;
    st = 32'h1;
    for (int i = 0; i < 5000 && st[0]; i++) regRead(A_STAT, st);
    armed = 1'b0;
    checkEq("R3 all expected words shifted", 32'(mosiQ.size()), 32'd0);
  endtask

  task automatic drainRx(input string tag);
    logic [31:0] d;
    while (rxQ.size() > 0) begin
      logic [31:0] e;
      e = rxQ.pop_front();
      regRead(A_RXD, d);
      checkEq(tag, d, e);
    end
  endtask

  // monitor side: assemble mosi at each sampling edge, then advance the slave
  always @(sclk) begin
    if (armed && (sclk == (curCpha ? curCpol : !curCpol))) begin
      mWord = {mWord[30:0], mosi};
      mCnt++;
      if (mCnt == curLen) begin
        monWords++;
        if (mosiQ.size() == 0) check(1'b0, "R3 extra word clocked", mWord, 32'h0);
        else begin
          logic [31:0] e;
          e = mosiQ.pop_front();
          check(mWord === e, "R2 mosi word", mWord, e);
        end
        mCnt = 0; mWord = '0;
      end
      #1;
      sPos--;
      if (sPos < 0) begin
        sWord = (slaveQ.size() > 0) ? slaveQ.pop_front() : 32'h0;
        sPos = curLen - 1;
      end
      miso = sWord[sPos];
    end
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] cmdA;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(A_STAT, d); checkEq("R1 status after reset", d, 32'h50);
    regRead(A_CMD, d);  checkEq("R1 command after reset", d, 32'h0);
    regRead(A_XFER, d); checkEq("R1 xfer after reset", d, 32'h0);
    checkEq("R1 sclk idle", 32'(sclk), 32'h0);
    checkEq("R1 csN idle", 32'(csN), 32'hF);
    checkEq("R1 irq low", 32'(irq), 32'h0);

    // mode 0, 8 bit, three words, full duplex
    cmdA = cmdWord(8, 0, 0, 1, 1, 4'b0001, 0, 0);
    setCmd(8, 0, 0, 1, 1, 4'b0001, 0, 0);
    checkEq("R7 cs0 selected", 32'(csN), 32'hE);
    regWrite(A_TXD, 32'hA5); regWrite(A_TXD, 32'h3C); regWrite(A_TXD, 32'hF0);
    addWord(32'hA5, 32'h5A, 1, 1); addWord(32'h3C, 32'hC3, 1, 1); addWord(32'hF0, 32'h0F, 1, 1);
    startBurst(2, 1, 0);
    regRead(A_STAT, d); checkEq("R8 busy during burst", d & 32'h1, 32'h1);
    regWrite(A_CMD, 32'h0);
    waitBurst();
    checkEq("R3 three words", 32'(monWords), 32'd3);
    regRead(A_STAT, d); checkEq("R8 ready after burst", d, 32'h42);
    checkEq("R11 irq tx enabled", 32'(irq), 32'h1);
    regRead(A_XFER, d); checkEq("R8 go self-clears", d, 32'h0001_0002);
    regRead(A_CMD, d);  checkEq("R8 command write ignored while busy", d, cmdA);
    drainRx("R5 rx word mode0");
    regWrite(A_STAT, 32'h2);
    regRead(A_STAT, d); checkEq("R9 ready write-one-clear", d, 32'h50);
    checkEq("R11 irq drops with ready", 32'(irq), 32'h0);

    // mode 3, 12 bit, four words
    setCmd(12, 1, 1, 1, 1, 4'b0001, 0, 0);
    checkEq("R4 sclk idles high", 32'(sclk), 32'h1);
    regWrite(A_TXD, 32'hABC); regWrite(A_TXD, 32'h123); regWrite(A_TXD, 32'hFFF); regWrite(A_TXD, 32'h800);
    addWord(32'hABC, 32'h5A5, 1, 1); addWord(32'h123, 32'h0F0, 1, 1);
    addWord(32'hFFF, 32'h001, 1, 1); addWord(32'h800, 32'hC3C, 1, 1);
    startBurst(3, 0, 0);
    waitBurst();
    regRead(A_STAT, d); checkEq("R9 rx full after four words", d, 32'h62);
    checkEq("R4 sclk back to idle high", 32'(sclk), 32'h1);
    drainRx("R4 rx word mode3");
    regWrite(A_STAT, 32'h2);

    // mode 2, 32 bit
    setCmd(32, 0, 1, 1, 1, 4'b0001, 0, 0);
    regWrite(A_TXD, 32'hDEAD_BEEF);
    addWord(32'hDEAD_BEEF, 32'h1234_5678, 1, 1);
    startBurst(0, 0, 0);
    waitBurst();
    drainRx("R4 rx word mode2 32 bit");
    regWrite(A_STAT, 32'h2);

    // mode 1, 5 bit
    setCmd(5, 1, 0, 1, 1, 4'b0001, 0, 0);
    regWrite(A_TXD, 32'h15); regWrite(A_TXD, 32'h0A);
    addWord(32'h15, 32'h1F, 1, 1); addWord(32'h0A, 32'h11, 1, 1);
    startBurst(1, 0, 0);
    waitBurst();
    drainRx("R4 rx word mode1 5 bit");
    regWrite(A_STAT, 32'h2);

    // burst clamped to queue depth
    setCmd(8, 0, 0, 1, 1, 4'b0001, 0, 0);
    for (int i = 0; i < 4; i++) begin
      regWrite(A_TXD, 32'(8'h11 * (i + 1)));
      addWord(32'(8'h11 * (i + 1)), 32'(8'h80 + i), 1, 1);
    end
    startBurst(9, 0, 0);
    waitBurst();
    checkEq("R3 burst clamped to four", 32'(monWords), 32'd4);
    drainRx("R3 rx word clamped burst");
    regWrite(A_STAT, 32'h2);

    // one bit words
    setCmd(1, 0, 0, 1, 1, 4'b0001, 0, 0);
    regWrite(A_TXD, 32'h1); regWrite(A_TXD, 32'h0);
    addWord(32'h1, 32'h0, 1, 1); addWord(32'h0, 32'h1, 1, 1);
    startBurst(1, 0, 0);
    waitBurst();
    drainRx("R2 rx one bit word");
    regWrite(A_STAT, 32'h2);

    // receive only: transmit queue must keep its word
    regWrite(A_TXD, 32'h77);
    setCmd(8, 0, 0, 0, 1, 4'b0001, 0, 0);
    addWord(32'h0, 32'h99, 0, 1); addWord(32'h0, 32'h66, 0, 1);
    startBurst(1, 0, 1);
    waitBurst();
    checkEq("R6 words clocked with tx off", 32'(monWords), 32'd2);
    regRead(A_STAT, d); checkEq("R6 tx queue untouched", d, 32'h02);
    checkEq("R11 irq rx enabled", 32'(irq), 32'h1);
    drainRx("R5 rx word read only");
    regWrite(A_STAT, 32'h2);

    // transmit only: receive queue stays empty, rx-only interrupt enable stays quiet
    setCmd(8, 0, 0, 1, 0, 4'b0001, 0, 0);
    regWrite(A_TXD, 32'h11);
    addWord(32'h77, 32'h33, 1, 0); addWord(32'h11, 32'h44, 1, 0);
    startBurst(1, 0, 1);
    waitBurst();
    regRead(A_STAT, d); checkEq("R5 rx queue empty with rx off", d, 32'h52);
    checkEq("R11 irq gated by rx enable", 32'(irq), 32'h0);
    regWrite(A_STAT, 32'h2);

    // overflow and underflow
    setCmd(8, 0, 0, 1, 1, 4'b0001, 0, 0);
    for (int i = 1; i <= 5; i++) regWrite(A_TXD, 32'(i));
    regRead(A_STAT, d); checkEq("R10 tx overflow flagged", d, 32'h98);
    regRead(A_RXD, d);  checkEq("R10 empty rx read returns zero", d, 32'h0);
    regRead(A_STAT, d); checkEq("R10 rx underflow flagged", d, 32'h9C);
    regWrite(A_STAT, 32'hC);
    regRead(A_STAT, d); checkEq("R9 error flags cleared", d, 32'h90);
    for (int i = 1; i <= 4; i++) addWord(32'(i), 32'(8'h40 + i), 1, 1);
    startBurst(3, 0, 0);
    waitBurst();
    regRead(A_STAT, d); checkEq("R10 dropped word not sent", d, 32'h62);
    drainRx("R10 rx word after overflow");
    regWrite(A_STAT, 32'h2);

    // chip-select mapping
    setCmd(8, 0, 0, 1, 1, 4'b1010, 1, 0);
    checkEq("R7 select level high", 32'(csN), 32'hF);
    setCmd(8, 0, 0, 1, 1, 4'b1010, 0, 0);
    checkEq("R7 select level low", 32'(csN), 32'h5);
    setCmd(8, 0, 0, 1, 1, 4'b1010, 0, 1);
    checkEq("R7 polarity invert", 32'(csN), 32'hA);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule